// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block generates the port-to-port interrupt flags that sit beside a dual-ported memory with 2K locations. Each of the two ports (A and B) presents the same access controls it drives into the memory: an active-low chip select, a read/write level (low means write), an active-low output enable, an 11-bit address and an active-low busy input from the contention arbiter. The block watches both ports and drives one active-low interrupt output per port. The memory array itself is not part of this block, and the two mailbox locations stay ordinary storage as far as the array is concerned.

Each port owns one mailbox word. Port A owns the location one below the top of the address space (0x7FE by default), and port B owns the top location (0x7FF). When one port writes the other port's mailbox, the owner's interrupt is raised. The owner acknowledges by reading its own mailbox with chip select and output enable both low. All inputs are sampled on the rising clock edge, and an interrupt output changes one cycle after the access that moves it. An enable input turns the whole function off.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs are high.
- R2: A port-A access with chip select low and read/write low at address 0x7FF drives `b_irq_no` low after the next rising edge.
- R3: A port-B access with chip select low and read/write low at address 0x7FE drives `a_irq_no` low after the next rising edge.
- R4: A port-B access at 0x7FF with chip select low and output enable low returns `b_irq_no` high after the next rising edge, whatever the port-B read/write level.
- R5: A port-A access at 0x7FE with chip select low and output enable low returns `a_irq_no` high after the next rising edge, whatever the port-A read/write level.
- R6: While a port's busy input is low, its set and clear actions have no effect and both flags keep their state.
- R7: When a set and a clear for the same flag fall in the same cycle, the flag ends set (output low).
- R8: While the enable input is low, both outputs are high after the next edge and no access sets a flag.
- R9: Writes to any address other than the opposite port's mailbox, writes by a port to its own mailbox, reads of a mailbox by the port that does not own it, and any access with chip select high leave both outputs unchanged.
- R10: A set flag stays set across idle cycles until a valid clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interrupt function enable, high to enable |
| a_cs_ni | input | 1 | Port A chip select, active low |
| a_we_ni | input | 1 | Port A read/write, low for write |
| a_oe_ni | input | 1 | Port A output enable, active low |
| a_addr_i | input | 11 | Port A address |
| a_busy_ni | input | 1 | Port A busy from arbiter, active low |
| b_cs_ni | input | 1 | Port B chip select, active low |
| b_we_ni | input | 1 | Port B read/write, low for write |
| b_oe_ni | input | 1 | Port B output enable, active low |
| b_addr_i | input | 11 | Port B address |
| b_busy_ni | input | 1 | Port B busy from arbiter, active low |
| a_irq_no | output | 1 | Interrupt to port A, active low |
| b_irq_no | output | 1 | Interrupt to port B, active low |

## Verification
The bench aims at the cases where the two mailbox addresses differ only in bit 0: a design that swapped or mis-decoded them would let a port interrupt itself or ignore the other side. It clears with the read/write level both high and low, which catches a clear wrongly gated by a read, and it pulls busy low on set and on clear separately, which catches a busy gate on only one path. A same-cycle set and clear shows whether the set really wins, and disabling with a flag pending shows whether the output is forced high at once.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_PORTS = 2;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic busy_n;
  } port_ctl_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int                ADDR_W   = 11,
  parameter logic [ADDR_W-1:0] SET_ADDR = '1,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              set_o,
  output logic              clr_o
);
  logic sel;

  assign sel   = !ctl_i.cs_n && ctl_i.busy_n;
  assign set_o = sel && !ctl_i.we_n && (addr_i == SET_ADDR);
  // clear ignores the read/write level
  assign clr_o = sel && !ctl_i.oe_n && (addr_i == CLR_ADDR);

  a_r6_busy_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.busy_n |-> !set_o && !clr_o);
  a_r9_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.cs_n |-> !set_o && !clr_o);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (!en_i)  flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign irq_no = ~flag_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && set_i |=> !irq_no);
  a_r4_clear_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && clr_i && !set_i |=> irq_no);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !set_i && !clr_i |=> $stable(irq_no));
  a_r8_disabled_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> irq_no);
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              a_cs_ni,
  input  logic              a_we_ni,
  input  logic              a_oe_ni,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_busy_ni,
  input  logic              b_cs_ni,
  input  logic              b_we_ni,
  input  logic              b_oe_ni,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_busy_ni,
  output logic              a_irq_no,
  output logic              b_irq_no
);
  // mailboxes: port A owns top-1, port B owns top
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] MBX_A    = TOP_ADDR ^ ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MBX_B    = TOP_ADDR;

  port_ctl_t         ctl  [NUM_PORTS];
  logic [ADDR_W-1:0] addr [NUM_PORTS];
  logic [NUM_PORTS-1:0] set_req, clr_req, irq_n;

  assign ctl[0]  = '{cs_n: a_cs_ni, we_n: a_we_ni, oe_n: a_oe_ni, busy_n: a_busy_ni};
  assign ctl[1]  = '{cs_n: b_cs_ni, we_n: b_we_ni, oe_n: b_oe_ni, busy_n: b_busy_ni};
  assign addr[0] = a_addr_i;
  assign addr[1] = b_addr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN   = (p == 0) ? MBX_A : MBX_B;
    localparam logic [ADDR_W-1:0] OTHER = (p == 0) ? MBX_B : MBX_A;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .SET_ADDR (OTHER),
      .CLR_ADDR (OWN)
    ) u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctl_i  (ctl[p]),
      .addr_i (addr[p]),
      .set_o  (set_req[p]),
      .clr_o  (clr_req[p])
    );

    // flag p is set by the opposite port, cleared by its owner
    mbx_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .set_i  (set_req[NUM_PORTS-1-p]),
      .clr_i  (clr_req[p]),
      .irq_no (irq_n[p])
    );
  end

  assign a_irq_no = irq_n[0];
  assign b_irq_no = irq_n[1];

  a_r2_a_write_raises_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !a_cs_ni && !a_we_ni && a_busy_ni && (a_addr_i == MBX_B) |=> !b_irq_no);
  a_r3_b_write_raises_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !b_cs_ni && !b_we_ni && b_busy_ni && (b_addr_i == MBX_A) |=> !a_irq_no);
  a_r6_busy_a_holds_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !a_busy_ni && b_cs_ni |=> $stable(b_irq_no));
  a_r6_busy_b_holds_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !b_busy_ni && a_cs_ni |=> $stable(a_irq_no));
endmodule

// File: tb/mbx_irq_ctrl_tb.sv
module mbx_irq_ctrl_tb;
  localparam logic [10:0] MA = 11'h7FE;
  localparam logic [10:0] MB = 11'h7FF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i;
  logic a_cs_ni, a_we_ni, a_oe_ni, a_busy_ni;
  logic b_cs_ni, b_we_ni, b_oe_ni, b_busy_ni;
  logic [10:0] a_addr_i, b_addr_i;
  logic a_irq_no, b_irq_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mbx_irq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .a_cs_ni(a_cs_ni), .a_we_ni(a_we_ni), .a_oe_ni(a_oe_ni),
    .a_addr_i(a_addr_i), .a_busy_ni(a_busy_ni),
    .b_cs_ni(b_cs_ni), .b_we_ni(b_we_ni), .b_oe_ni(b_oe_ni),
    .b_addr_i(b_addr_i), .b_busy_ni(b_busy_ni),
    .a_irq_no(a_irq_no), .b_irq_no(b_irq_no)
  );

  task automatic idle();
    a_cs_ni = 1; a_we_ni = 1; a_oe_ni = 1; a_addr_i = '0; a_busy_ni = 1;
    b_cs_ni = 1; b_we_ni = 1; b_oe_ni = 1; b_addr_i = '0; b_busy_ni = 1;
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
    idle();
  endtask

  task automatic acc_a(input logic cs, we, oe, busy, input logic [10:0] ad);
    a_cs_ni = cs; a_we_ni = we; a_oe_ni = oe; a_busy_ni = busy; a_addr_i = ad;
  endtask

  task automatic acc_b(input logic cs, we, oe, busy, input logic [10:0] ad);
    b_cs_ni = cs; b_we_ni = we; b_oe_ni = oe; b_busy_ni = busy; b_addr_i = ad;
  endtask

  task automatic chk(input logic exp_a, exp_b, input string req);
    checks++;
    if (a_irq_no !== exp_a || b_irq_no !== exp_b) begin
      errors++;
      $display("FAIL %s: a_irq_no=%b b_irq_no=%b expected %b %b",
               req, a_irq_no, b_irq_no, exp_a, exp_b);
    end
  endtask

  task automatic t_reset();
    chk(1, 1, "R1 reset");
  endtask

  task automatic t_set_clear_b();
    acc_a(0, 0, 1, 1, MB); step(); chk(1, 0, "R2 A writes B mailbox");
    step(); step(); chk(1, 0, "R10 hold");
    acc_b(0, 0, 0, 1, MB); step(); chk(1, 1, "R4 clear with we low");
    acc_a(0, 0, 1, 1, MB); step();
    acc_b(0, 1, 0, 1, MB); step(); chk(1, 1, "R4 clear with we high");
  endtask

  task automatic t_set_clear_a();
    acc_b(0, 0, 1, 1, MA); step(); chk(0, 1, "R3 B writes A mailbox");
    step(); chk(0, 1, "R10 hold");
    acc_a(0, 0, 0, 1, MA); step(); chk(1, 1, "R5 clear with we low");
    acc_b(0, 0, 1, 1, MA); step();
    acc_a(0, 1, 0, 1, MA); step(); chk(1, 1, "R5 clear with we high");
  endtask

  task automatic t_busy();
    acc_a(0, 0, 1, 0, MB); step(); chk(1, 1, "R6 busy blocks set");
    acc_a(0, 0, 1, 1, MB); step();
    acc_b(0, 1, 0, 0, MB); step(); chk(1, 0, "R6 busy blocks clear");
    acc_b(0, 1, 0, 1, MB); step(); chk(1, 1, "R6 clear after busy");
  endtask

  task automatic t_priority();
    acc_a(0, 0, 1, 1, MB); acc_b(0, 1, 0, 1, MB); step();
    chk(1, 0, "R7 set wins from clear");
    acc_a(0, 0, 1, 1, MB); acc_b(0, 1, 0, 1, MB); step();
    chk(1, 0, "R7 set wins when set");
    acc_b(0, 1, 0, 1, MB); step();
    acc_b(0, 0, 1, 1, MA); acc_a(0, 1, 0, 1, MA); step();
    chk(0, 1, "R7 set wins on A");
    acc_a(0, 1, 0, 1, MA); step(); chk(1, 1, "R7 cleanup");
  endtask

  task automatic t_no_effect();
    acc_a(0, 0, 1, 1, MA); step(); chk(1, 1, "R9 A writes own mailbox");
    acc_b(0, 0, 1, 1, MB); step(); chk(1, 1, "R9 B writes own mailbox");
    acc_a(1, 0, 1, 1, MB); step(); chk(1, 1, "R9 A deselected write");
    acc_a(0, 0, 1, 1, 11'h7FD); acc_b(0, 0, 1, 1, 11'h3FE); step();
    chk(1, 1, "R9 other addresses");
    acc_a(0, 0, 1, 1, MB); step();
    acc_a(0, 1, 0, 1, MB); step(); chk(1, 0, "R9 non-owner read");
    acc_b(1, 1, 0, 1, MB); step(); chk(1, 0, "R9 owner deselected read");
    acc_b(0, 1, 1, 1, MB); step(); chk(1, 0, "R9 owner read, oe high");
    acc_b(0, 1, 0, 1, MB); step(); chk(1, 1, "R9 cleanup");
  endtask

  task automatic t_disable();
    acc_a(0, 0, 1, 1, MB); acc_b(0, 0, 1, 1, MA); step();
    chk(0, 0, "R8 both set before disable");
    en_i = 0; step(); chk(1, 1, "R8 disable forces high");
    acc_a(0, 0, 1, 1, MB); acc_b(0, 0, 1, 1, MA); step();
    chk(1, 1, "R8 sets ignored while off");
    en_i = 1; step(); chk(1, 1, "R8 stays clear on re-enable");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    en_i = 1;
    idle();
    repeat (3) @(posedge clk_i);
    #2;
    t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_set_clear_b();
    t_set_clear_a();
    t_busy();
    t_priority();
    t_no_effect();
    t_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule